// File: doc/BRIEF.md
# Double-Buffered Control and Status Register Bank

This block is a small register bank on a simple host write bus with combinational read data. It holds three kinds of bits. Staged control fields have two copies. The host writes the staged copy. A separate working copy lives in a target clock domain, and only that copy drives the block's output. The staged value moves to the working copy only when the host issues a commit strobe. The strobe crosses into the target domain through a toggle synchronizer. Sticky event bits are set by hardware and cleared by the host writing ones. Fixed-input bits show a hardware value and ignore writes. A plain scratch register is also provided.

The bank has two kinds of reset. The asynchronous hardware reset clears everything. A host-requested soft reset clears only the working copies and the sticky event bits. It holds each clock domain in that cleared state for a parameterised number of that domain's own clock cycles, and then the request bit clears itself. Staged copies and the scratch register keep their contents through a soft reset.

Top module: `regbank_dbuf`

Address map used below, with the default 8-bit data path: 0 = command (bit 0 commit, bit 1 soft reset / busy flag), 1 = scratch, 2 = sticky events, 3 = fixed input, 4 + i = staged field i, 8 + i = working field i readback. Unmapped addresses read 0.

## Requirements
- R1: After hardware reset the following all read 0: the staged fields, the scratch register, the sticky events, the working-field readback and `active_out`.
- R2: A write to address 4 + i stores field i in its staged copy, and a read of 4 + i returns that staged value.
- R3: Writing the command register with bit 0 = 1 copies every staged field into its working copy. The copy happens on the first target-clock edge after the synchronized strobe is detected. It then appears on `active_out` (field i at bits [8i+7:8i]) and at readback address 8 + i.
- R4: Without a commit, the working copies do not change, even when the staged copies are rewritten.
- R5: A high `sts_set[k]` sets event bit k at address 2, and the bit stays set. Writing 1 to bit k clears it, and writing 0 leaves it unchanged.
- R6: When a set of event bit k and a write-1 clear of that bit fall in the same cycle, the bit ends up set.
- R7: Address 3 returns `ro_in`. A write to address 3 changes no register.
- R8: Writing the command register with bit 1 = 1 starts a soft reset. It clears the event bits and the working copies, and command bit 1 reads 1 for RST_CYC host cycles before it clears by itself.
- R9: A soft reset leaves the staged copies and the scratch register unchanged.
- R10: While a domain is held in soft reset, event sets (host domain) and commits (target domain) are ignored.
- R11: Address 1 is a plain read/write register whose value drives `rw_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_host | input | 1 | Host bus clock |
| clk_tgt | input | 1 | Target domain clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_we | input | 1 | Write enable |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` |
| sts_set | input | NUM_STS | Hardware event set pulses |
| ro_in | input | DW | Fixed-input value |
| rw_out | output | DW | Scratch register value |
| active_out | output | NUM_PA*DW | Working copies (target domain) |

## Verification
Two collisions are checked. The first is a hardware event set and a host write-1-clear that hit the same event bit in the same host cycle. The bench drives `sts_set` and the clearing write on the same negative edge. It expects the collided bit to stay set while a different bit cleared by the same write is cleared. The second is a commit strobe issued while the target domain is still held by a soft reset. The bench judges it by checking that `active_out` is still zero after the hold has ended, and that a later commit does take effect.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int RB_ADDR_CMD   = 0;
  localparam int RB_ADDR_RW    = 1;
  localparam int RB_ADDR_EVT   = 2;
  localparam int RB_ADDR_FIX   = 3;
  localparam int RB_PEND_BASE  = 4;
  localparam int RB_ACT_BASE   = 8;
  localparam int RB_CMD_COMMIT = 0;
  localparam int RB_CMD_SRST   = 1;
endpackage

// File: rtl/rb_rst_sync.sv
module rb_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) stg_q <= 2'b00;
    else           stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_out_n = stg_q[1];
endmodule

// File: rtl/rb_toggle_sync.sv
module rb_toggle_sync (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic pulse_in,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic pulse_out
);
  logic       tog_q, tog_d;
  logic [2:0] sync_q, sync_d;

  always_comb tog_d = tog_q ^ pulse_in;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tog_q <= 1'b0;
    else            tog_q <= tog_d;
  end

  always_comb sync_d = {sync_q[1:0], tog_q};

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) sync_q <= 3'b000;
    else            sync_q <= sync_d;
  end

  assign pulse_out = sync_q[2] ^ sync_q[1];
endmodule

// File: rtl/rb_bus_sync.sv
module rb_bus_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/rb_host_regs.sv
module rb_host_regs
  import regbank_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 4,
  parameter int NUM_PA  = 2,
  parameter int NUM_STS = 4,
  parameter int RST_CYC = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NUM_STS-1:0]   sts_set,
  input  logic [DW-1:0]        ro_in,
  input  logic [NUM_PA*DW-1:0] act_rb,
  output logic [NUM_PA*DW-1:0] pend_flat,
  output logic [DW-1:0]        rw_out,
  output logic                 upd_pulse,
  output logic                 soft_pulse
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic [NUM_PA-1:0][DW-1:0] pend_q, pend_d;
  logic [NUM_PA-1:0][DW-1:0] act_v;
  logic [NUM_PA-1:0]         pend_we;
  logic [DW-1:0]             rw_q, rw_d;
  logic [NUM_STS-1:0]        evt_q, evt_d, evt_clr;
  logic                      busy_q, busy_d;
  logic [CW-1:0]             cnt_q, cnt_d;
  logic                      wr_cmd, wr_rw, wr_evt, soft_hold, pend_wr_any;

  assign act_v = act_rb;

  // address decode
  always_comb begin
    wr_cmd = bus_we && (int'(bus_addr) == RB_ADDR_CMD);
    wr_rw  = bus_we && (int'(bus_addr) == RB_ADDR_RW);
    wr_evt = bus_we && (int'(bus_addr) == RB_ADDR_EVT);
    for (int i = 0; i < NUM_PA; i++)
      pend_we[i] = bus_we && (int'(bus_addr) == RB_PEND_BASE + i);
    pend_wr_any = |pend_we;
  end

  // next state
  always_comb begin
    pend_d = pend_q;
    for (int i = 0; i < NUM_PA; i++)
      if (pend_we[i]) pend_d[i] = bus_wdata;

    rw_d = wr_rw ? bus_wdata : rw_q;

    soft_pulse = wr_cmd && bus_wdata[RB_CMD_SRST] && !busy_q;
    upd_pulse  = wr_cmd && bus_wdata[RB_CMD_COMMIT];
    soft_hold  = soft_pulse || busy_q;

    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (soft_pulse) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(RST_CYC - 1)) busy_d = 1'b0;
      else                           cnt_d  = cnt_q + 1'b1;
    end

    evt_clr = wr_evt ? bus_wdata[NUM_STS-1:0] : '0;
    if (soft_hold) evt_d = '0;
    else           evt_d = (evt_q & ~evt_clr) | sts_set;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      rw_q   <= '0;
      evt_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      rw_q   <= rw_d;
      evt_q  <= evt_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) == RB_ADDR_CMD)      bus_rdata[RB_CMD_SRST] = busy_q;
    else if (int'(bus_addr) == RB_ADDR_RW)  bus_rdata = rw_q;
    else if (int'(bus_addr) == RB_ADDR_EVT) bus_rdata[NUM_STS-1:0] = evt_q;
    else if (int'(bus_addr) == RB_ADDR_FIX) bus_rdata = ro_in;
    for (int i = 0; i < NUM_PA; i++) begin
      if (int'(bus_addr) == RB_PEND_BASE + i) bus_rdata = pend_q[i];
      if (int'(bus_addr) == RB_ACT_BASE + i)  bus_rdata = act_v[i];
    end
  end

  assign pend_flat = pend_q;
  assign rw_out    = rw_q;

  // R6: a set pulse always leaves its bit set, clear or not
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_hold |=> ((evt_q & $past(sts_set)) == $past(sts_set)));

  // R8: soft reset empties the event bits
  assert_soft_clears_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_hold |=> (evt_q == '0));

  // R9: staged copies survive a soft reset request
  assert_soft_keeps_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_pulse && !pend_wr_any) |=> $stable(pend_q));

  // R5: without a set or clear, event bits hold
  assert_evt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_hold && !wr_evt && (sts_set == '0)) |=> $stable(evt_q));
endmodule

// File: rtl/rb_active_bank.sv
module rb_active_bank #(
  parameter int                     DW      = 8,
  parameter int                     NUM_PA  = 2,
  parameter int                     RST_CYC = 64,
  parameter logic [NUM_PA*DW-1:0]   ACT_RST = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_p,
  input  logic                 soft_p,
  input  logic [NUM_PA*DW-1:0] pend_flat,
  output logic [NUM_PA*DW-1:0] active_flat
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic [NUM_PA*DW-1:0] act_q, act_d;
  logic                 busy_q, busy_d, hold;
  logic [CW-1:0]        cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (soft_p) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(RST_CYC - 1)) busy_d = 1'b0;
      else                           cnt_d  = cnt_q + 1'b1;
    end
    hold = soft_p || busy_q;

    if (hold)       act_d = ACT_RST;
    else if (upd_p) act_d = pend_flat;
    else            act_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= ACT_RST;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign active_flat = act_q;

  // R4: working copies move only on a commit
  assert_act_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_p && !hold) |=> $stable(act_q));

  // R10: a commit under soft-reset hold leaves the default in place
  assert_hold_blocks_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (act_q == ACT_RST));
endmodule

// File: rtl/regbank_dbuf.sv
module regbank_dbuf #(
  parameter int                   DW      = 8,
  parameter int                   AW      = 4,
  parameter int                   NUM_PA  = 2,
  parameter int                   NUM_STS = 4,
  parameter int                   RST_CYC = 64,
  parameter logic [NUM_PA*DW-1:0] ACT_RST = '0
) (
  input  logic                 clk_host,
  input  logic                 clk_tgt,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NUM_STS-1:0]   sts_set,
  input  logic [DW-1:0]        ro_in,
  output logic [DW-1:0]        rw_out,
  output logic [NUM_PA*DW-1:0] active_out
);
  logic                 hrst_n, trst_n;
  logic                 upd_h, soft_h, upd_t, soft_t;
  logic [NUM_PA*DW-1:0] pend_flat, act_rb;

  rb_rst_sync u_hrst (.clk(clk_host), .rst_in_n(rst_n), .rst_out_n(hrst_n));
  rb_rst_sync u_trst (.clk(clk_tgt),  .rst_in_n(rst_n), .rst_out_n(trst_n));

  rb_host_regs #(
    .DW(DW), .AW(AW), .NUM_PA(NUM_PA), .NUM_STS(NUM_STS), .RST_CYC(RST_CYC)
  ) u_host (
    .clk(clk_host), .rst_n(hrst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sts_set(sts_set),
    .ro_in(ro_in), .act_rb(act_rb), .pend_flat(pend_flat), .rw_out(rw_out),
    .upd_pulse(upd_h), .soft_pulse(soft_h)
  );

  rb_toggle_sync u_upd_sync (
    .src_clk(clk_host), .src_rst_n(hrst_n), .pulse_in(upd_h),
    .dst_clk(clk_tgt),  .dst_rst_n(trst_n), .pulse_out(upd_t)
  );

  rb_toggle_sync u_soft_sync (
    .src_clk(clk_host), .src_rst_n(hrst_n), .pulse_in(soft_h),
    .dst_clk(clk_tgt),  .dst_rst_n(trst_n), .pulse_out(soft_t)
  );

  rb_active_bank #(
    .DW(DW), .NUM_PA(NUM_PA), .RST_CYC(RST_CYC), .ACT_RST(ACT_RST)
  ) u_act (
    .clk(clk_tgt), .rst_n(trst_n), .upd_p(upd_t), .soft_p(soft_t),
    .pend_flat(pend_flat), .active_flat(active_out)
  );

  rb_bus_sync #(.W(NUM_PA*DW)) u_act_rb (
    .clk(clk_host), .rst_n(hrst_n), .d(active_out), .q(act_rb)
  );

  // R7: the fixed-input address reads straight through
  always_comb begin
    if (hrst_n && !$isunknown(bus_addr) && int'(bus_addr) == 3)
      assert_fix_passthru_R7: assert (bus_rdata == ro_in);
  end
endmodule

// File: tb/regbank_dbuf_tb.sv
module regbank_dbuf_tb;
  logic        clk_host = 1'b0, clk_tgt = 1'b0, rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata, rw_out;
  logic [3:0]  sts_set = '0;
  logic [7:0]  ro_in = 8'hA5;
  logic [15:0] active_out;
  int checks = 0, errors = 0;

  always #4 clk_host = ~clk_host;
  always #6 clk_tgt  = ~clk_tgt;

  regbank_dbuf u_dut (
    .clk_host(clk_host), .clk_tgt(clk_tgt), .rst_n(rst_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sts_set(sts_set), .ro_in(ro_in), .rw_out(rw_out), .active_out(active_out)
  );

  // vector: {is_read, addr, data, expected, requirement number}
  localparam int NV = 15;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 4'h1, 8'h00, 8'h00, 4'd1},   // R1 scratch
    {1'b1, 4'h2, 8'h00, 8'h00, 4'd1},   // R1 events
    {1'b1, 4'h4, 8'h00, 8'h00, 4'd1},   // R1 staged
    {1'b1, 4'h8, 8'h00, 8'h00, 4'd1},   // R1 working readback
    {1'b0, 4'h1, 8'h3C, 8'h00, 4'd11},  // R11 write
    {1'b1, 4'h1, 8'h00, 8'h3C, 4'd11},  // R11 read
    {1'b0, 4'h4, 8'h11, 8'h00, 4'd2},   // R2 write
    {1'b0, 4'h5, 8'h22, 8'h00, 4'd2},   // R2 write
    {1'b1, 4'h4, 8'h00, 8'h11, 4'd2},   // R2 read
    {1'b1, 4'h5, 8'h00, 8'h22, 4'd2},   // R2 read
    {1'b1, 4'h8, 8'h00, 8'h00, 4'd4},   // R4 no commit yet
    {1'b0, 4'h3, 8'hFF, 8'h00, 4'd7},   // R7 write ignored
    {1'b1, 4'h3, 8'h00, 8'hA5, 4'd7},   // R7 reads input
    {1'b1, 4'h1, 8'h00, 8'h3C, 4'd7},   // R7 scratch untouched
    {1'b1, 4'h5, 8'h00, 8'h22, 4'd7}    // R7 staged untouched
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_host);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk_host);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_host);
    bus_addr = a;
    #1;
    chk(req, {24'd0, bus_rdata}, {24'd0, exp});
  endtask

  task automatic pulse_evt(input logic [3:0] v);
    @(negedge clk_host);
    sts_set = v;
    @(negedge clk_host);
    sts_set = '0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk_host);
  endtask

  initial begin
    repeat (20000) @(posedge clk_host);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    waitc(3);
    rst_n = 1'b1;
    waitc(5);
    chk("R1", {16'd0, active_out}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][24]) rd(VEC[v][23:20], VEC[v][11:4], $sformatf("R%0d", VEC[v][3:0]));
      else            wr(VEC[v][23:20], VEC[v][19:12]);
    end

    chk("R11", {24'd0, rw_out}, 32'h3C);

    // R3 commit
    wr(4'h0, 8'h01);
    waitc(20);
    chk("R3", {16'd0, active_out}, 32'h2211);
    rd(4'h8, 8'h11, "R3");
    rd(4'h9, 8'h22, "R3");

    // R4 rewrite staged without commit
    wr(4'h4, 8'h77);
    waitc(20);
    chk("R4", {16'd0, active_out}, 32'h2211);
    rd(4'h8, 8'h11, "R4");

    // R5 sticky and write-1-clear
    pulse_evt(4'b0101);
    rd(4'h2, 8'h05, "R5");
    wr(4'h2, 8'h01);
    rd(4'h2, 8'h04, "R5");
    wr(4'h2, 8'h00);
    rd(4'h2, 8'h04, "R5");

    // R6 set and clear of bit 1 collide, bit 2 cleared by the same write
    @(negedge clk_host);
    bus_we = 1'b1; bus_addr = 4'h2; bus_wdata = 8'h06; sts_set = 4'b0010;
    @(negedge clk_host);
    bus_we = 1'b0; sts_set = '0;
    rd(4'h2, 8'h02, "R6");

    // commit 77/22 before soft reset
    wr(4'h0, 8'h01);
    waitc(20);
    chk("R3", {16'd0, active_out}, 32'h2277);
    pulse_evt(4'b1000);
    rd(4'h2, 8'h0A, "R5");

    // R8 soft reset
    wr(4'h0, 8'h02);
    rd(4'h0, 8'h02, "R8");
    rd(4'h2, 8'h00, "R8");
    rd(4'h1, 8'h3C, "R9");
    rd(4'h4, 8'h77, "R9");
    rd(4'h5, 8'h22, "R9");
    pulse_evt(4'b0001);
    rd(4'h2, 8'h00, "R10");
    waitc(12);
    chk("R8", {16'd0, active_out}, 32'd0);
    wr(4'h0, 8'h01);          // commit under hold, R10
    waitc(60);
    rd(4'h0, 8'h00, "R8");
    waitc(70);
    chk("R10", {16'd0, active_out}, 32'd0);
    chk("R9", {24'd0, rw_out}, 32'h3C);
    wr(4'h0, 8'h01);
    waitc(20);
    chk("R3", {16'd0, active_out}, 32'h2277);
    rd(4'h8, 8'h77, "R9");

    // R1 hardware reset mid-run
    @(negedge clk_host);
    rst_n = 1'b0;
    waitc(3);
    rst_n = 1'b1;
    waitc(6);
    rd(4'h4, 8'h00, "R1");
    rd(4'h1, 8'h00, "R1");
    rd(4'h2, 8'h00, "R1");
    chk("R1", {16'd0, active_out}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule